// File: doc/BRIEF.md
# Register-Mapped BCD Calendar Clock Bridge

This block lets a host processor set and read a calendar clock through three word registers: a control/status word and two data words. A date and time travel across the bus as one packed record of seven BCD bytes (year since 2000, month, day, weekday, hour, minute, second). The host fills the data words, then writes a command code into the control word. The bridge spends a fixed number of cycles on the transfer to its internal timekeeping core. When the transfer ends it raises a ready flag and reports the outcome in an error flag.

The timekeeping core steps the calendar once for each single-cycle pulse on a once-per-second tick input. It carries seconds into minutes, hours, day, month and year, all in BCD. The weekday wraps at midnight, and February has 29 days in years divisible by four.

The host follows a fixed sequence. It polls the ready flag, writes zero to the control word, loads the data words (low then high), writes the command, and polls ready again. Zero is also the only way to re-arm the bridge after any command has finished. The bus is a plain single-cycle register port with a combinational read path. It has no back-pressure: the ready flag is the only flow control, and the host must honour it.

Top module: `rtc_cmd_bridge`

## Requirements
- R1: After reset the control word reads 0x8000, and a read command returns year 00, month 01, day 01, weekday 6, 00:00:00 (low word 0x06010100, high word 0x00000000).
- R2: Word address 0 is control, 1 is the low data word and 2 is the high data word. The low word holds year in bits 7:0, month in 15:8, day in 23:16 and weekday in 31:24. The high word holds hour in 7:0, minute in 15:8 and second in 23:16, and bits 31:24 read zero.
- R3: Once a set or read command is accepted, control bit 15 (ready) reads 0 for exactly CMD_CYCLES clock cycles and then returns to 1.
- R4: Command 1 (set) with a valid record loads the record into the clock and leaves bit 14 (error) clear. Control bits 1:0 show the last accepted command code.
- R5: A set with any non-BCD nibble, month outside 01–12, day outside 01 to the month length, hour above 23, minute or second above 59, or weekday above 6 sets bit 14 and leaves the clock unchanged.
- R6: Command 2 (read) copies the current clock into the data words and leaves bit 14 clear.
- R7: Writing 0 to control clears bit 14 and bits 1:0 and re-arms the bridge. After any command completes, commands 1 and 2 are ignored until 0 is written.
- R8: While busy, control writes and data-word writes are ignored. Control values other than 0, 1 and 2 are always ignored and leave the control word unchanged.
- R9: Each tick pulse advances the second with BCD carry through minute, hour, day, month and year (99 wraps to 00). The weekday wraps from 6 to 0 at midnight.
- R10: Months 04, 06, 09 and 11 have 30 days. February has 29 days when the BCD year is divisible by 4 and 28 otherwise. All other months have 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_pps | input | 1 | Single-cycle once-per-second advance pulse |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |

## Verification
The bench builds the bridge with CMD_CYCLES = 8 and ADDR_W = 2. It counts the busy window cycle by cycle against that value on every command. The same count fixes when a control write lands in the busy window, so a second command and a data write can be placed there deliberately.

Validation is driven from a vector table of good and bad records. Each bad record is followed by a read that confirms the time did not move.

The tick tests set the clock to one second before each kind of boundary, then apply a single pulse. This covers a minute rollover, 30-day months, leap and non-leap February, and the end of the century with the weekday wrap.

// File: rtl/rtc_bridge_pkg.sv
package rtc_bridge_pkg;

  localparam int REG_W     = 32;
  localparam int CTRL_W    = 16;
  localparam int READY_BIT = 15;
  localparam int ERR_BIT   = 14;

  localparam logic [CTRL_W-1:0] CMD_CLEAR = 16'd0;
  localparam logic [CTRL_W-1:0] CMD_SET   = 16'd1;
  localparam logic [CTRL_W-1:0] CMD_GET   = 16'd2;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_SET  = 2'd1,
    OP_GET  = 2'd2
  } op_e;

  // BCD calendar record, first field most significant
  typedef struct packed {
    logic [7:0] yr;
    logic [7:0] mo;
    logic [7:0] dy;
    logic [7:0] dw;
    logic [7:0] hr;
    logic [7:0] mi;
    logic [7:0] se;
  } rtc_time_t;

  localparam int TIME_W  = $bits(rtc_time_t);
  localparam int NIBBLES = TIME_W / 4;

  localparam rtc_time_t RESET_TIME = '{yr: 8'h00, mo: 8'h01, dy: 8'h01,
                                       dw: 8'h06, hr: 8'h00, mi: 8'h00,
                                       se: 8'h00};

  function automatic logic [7:0] bcd_to_bin(input logic [7:0] b);
    return 8'(b[7:4]) * 8'd10 + 8'(b[3:0]);
  endfunction

  function automatic logic [7:0] bcd_inc(input logic [7:0] b);
    if (b[3:0] >= 4'd9) return {b[7:4] + 4'd1, 4'd0};
    return {b[7:4], b[3:0] + 4'd1};
  endfunction

  // Last day of the month, in BCD
  function automatic logic [7:0] month_len(input logic [7:0] mo,
                                           input logic [7:0] yr);
    logic [7:0] ybin;
    ybin = bcd_to_bin(yr);
    case (mo)
      8'h02:                      return (ybin[1:0] == 2'd0) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  function automatic rtc_time_t regs_to_time(input logic [31:0] lo,
                                             input logic [31:0] hi);
    rtc_time_t t;
    t.yr = lo[7:0];
    t.mo = lo[15:8];
    t.dy = lo[23:16];
    t.dw = lo[31:24];
    t.hr = hi[7:0];
    t.mi = hi[15:8];
    t.se = hi[23:16];
    return t;
  endfunction

endpackage

// File: rtl/rtc_rec_check.sv
module rtc_rec_check
  import rtc_bridge_pkg::*;
(
  input  rtc_time_t rec,
  output logic      rec_ok
);

  logic [TIME_W-1:0]  flat;
  logic [NIBBLES-1:0] nib_ok;
  logic [7:0]         last_day;
  logic               range_ok;

  assign flat = rec;

  for (genvar i = 0; i < NIBBLES; i++) begin : g_nib
    assign nib_ok[i] = (flat[i*4 +: 4] <= 4'd9);
  end

  assign last_day = month_len(rec.mo, rec.yr);

  // With every nibble decimal, BCD bytes compare like binary numbers
  always_comb begin
    range_ok = (rec.mo >= 8'h01) && (rec.mo <= 8'h12) &&
               (rec.dy >= 8'h01) && (rec.dy <= last_day) &&
               (rec.hr <= 8'h23) && (rec.mi <= 8'h59) &&
               (rec.se <= 8'h59) && (rec.dw <= 8'h06);
  end

  assign rec_ok = (&nib_ok) && range_ok;

endmodule

// File: rtl/rtc_timekeeper.sv
module rtc_timekeeper
  import rtc_bridge_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      load_en,
  input  rtc_time_t load_val,
  output rtc_time_t now
);

  rtc_time_t nxt;
  logic      c_mi, c_hr, c_dy, c_mo, c_yr;

  always_comb begin
    nxt  = now;
    c_mi = (now.se == 8'h59);
    c_hr = c_mi && (now.mi == 8'h59);
    c_dy = c_hr && (now.hr == 8'h23);
    c_mo = c_dy && (now.dy == month_len(now.mo, now.yr));
    c_yr = c_mo && (now.mo == 8'h12);

    nxt.se = c_mi ? 8'h00 : bcd_inc(now.se);
    if (c_mi) nxt.mi = c_hr ? 8'h00 : bcd_inc(now.mi);
    if (c_hr) nxt.hr = c_dy ? 8'h00 : bcd_inc(now.hr);
    if (c_dy) begin
      nxt.dy = c_mo ? 8'h01 : bcd_inc(now.dy);
      nxt.dw = (now.dw >= 8'h06) ? 8'h00 : now.dw + 8'h01;
    end
    if (c_mo) nxt.mo = c_yr ? 8'h01 : bcd_inc(now.mo);
    if (c_yr) nxt.yr = (now.yr == 8'h99) ? 8'h00 : bcd_inc(now.yr);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       now <= RESET_TIME;
    else if (load_en) now <= load_val;
    else if (tick)    now <= nxt;
  end

  // R9: time moves only on a tick or a load
  p_hold_without_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load_en) |=> $stable(now));

  // R9: seconds always hold a legal BCD value
  p_sec_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (now.se[3:0] <= 4'd9) && (now.se <= 8'h59));

  // R10: the day never passes the length of its month
  p_day_in_month_r10: assert property (@(posedge clk) disable iff (!rst_n)
    now.dy <= month_len(now.mo, now.yr));

endmodule

// File: rtl/rtc_cmd_fsm.sv
module rtc_cmd_fsm
  import rtc_bridge_pkg::*;
#(
  parameter int CMD_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  input  logic              rec_ok,
  output logic              busy,
  output logic              err,
  output logic [1:0]        last_op,
  output logic              load_en,
  output logic              capture_en
);

  localparam int CNT_W = $clog2(CMD_CYCLES + 1);

  logic [CNT_W-1:0] cnt;
  op_e              op;
  logic             armed;
  logic             done, is_clear, is_start;

  assign done     = busy && (cnt == '0);
  assign is_clear = ctrl_we && !busy && (ctrl_wdata == CMD_CLEAR);
  assign is_start = ctrl_we && !busy && armed &&
                    ((ctrl_wdata == CMD_SET) || (ctrl_wdata == CMD_GET));

  assign load_en    = done && (op == OP_SET) && rec_ok;
  assign capture_en = done && (op == OP_GET);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      cnt     <= '0;
      op      <= OP_NONE;
      armed   <= 1'b1;
      err     <= 1'b0;
      last_op <= OP_NONE;
    end else begin
      if (done) begin
        busy  <= 1'b0;
        armed <= 1'b0;
        err   <= (op == OP_SET) ? !rec_ok : 1'b0;
      end else if (is_clear) begin
        err     <= 1'b0;
        armed   <= 1'b1;
        last_op <= OP_NONE;
      end else if (is_start) begin
        busy    <= 1'b1;
        cnt     <= CNT_W'(CMD_CYCLES - 1);
        op      <= op_e'(ctrl_wdata[1:0]);
        last_op <= ctrl_wdata[1:0];
      end
      if (busy && (cnt != '0)) cnt <= cnt - 1'b1;
    end
  end

  // R3: an accepted command makes the bridge busy on the next cycle
  p_start_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    is_start |=> busy);

  // R3: the countdown stays inside the window
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt < CNT_W'(CMD_CYCLES)));

  // R7: the error flag changes only at completion or on a clear
  p_err_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && !is_clear) |=> $stable(err));

  // R8: a control write in the busy window neither stops nor retargets it
  p_busy_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && ctrl_we) |=> (busy && $stable(op) && $stable(last_op)));

  // R7: completion leaves the bridge idle
  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

endmodule

// File: rtl/rtc_cmd_bridge.sv
module rtc_cmd_bridge
  import rtc_bridge_pkg::*;
#(
  parameter int CMD_CYCLES = 8,
  parameter int ADDR_W     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_pps,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata
);

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_LO   = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_HI   = ADDR_W'(2);

  logic [31:0] data_lo;
  logic [23:0] data_hi;
  logic        busy, err, load_en, capture_en, rec_ok;
  logic [1:0]  last_op;
  rtc_time_t   rec, now;

  assign rec = regs_to_time(data_lo, {8'h00, data_hi});

  rtc_rec_check u_check (
    .rec    (rec),
    .rec_ok (rec_ok)
  );

  rtc_cmd_fsm #(.CMD_CYCLES(CMD_CYCLES)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_we    (bus_we && (bus_addr == A_CTRL)),
    .ctrl_wdata (bus_wdata[CTRL_W-1:0]),
    .rec_ok     (rec_ok),
    .busy       (busy),
    .err        (err),
    .last_op    (last_op),
    .load_en    (load_en),
    .capture_en (capture_en)
  );

  rtc_timekeeper u_tk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick_pps),
    .load_en  (load_en),
    .load_val (rec),
    .now      (now)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_lo <= '0;
      data_hi <= '0;
    end else if (capture_en) begin
      data_lo <= {now.dw, now.dy, now.mo, now.yr};
      data_hi <= {now.se, now.mi, now.hr};
    end else if (bus_we && !busy) begin
      if (bus_addr == A_LO) data_lo <= bus_wdata;
      if (bus_addr == A_HI) data_hi <= bus_wdata[23:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL:  bus_rdata[CTRL_W-1:0] = {!busy, err, 12'h000, last_op};
      A_LO:    bus_rdata = data_lo;
      A_HI:    bus_rdata = {8'h00, data_hi};
      default: bus_rdata = '0;
    endcase
  end

  // R5: the clock is loaded only from a record that passed validation
  p_load_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |-> rec_ok);

  // R8: data words hold through the busy window unless a read lands
  p_data_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !capture_en) |=> ($stable(data_lo) && $stable(data_hi)));

endmodule

// File: tb/rtc_cmd_bridge_tb.sv
module rtc_cmd_bridge_tb;

  localparam int CLK_PERIOD = 10;
  localparam int CMD_CYC    = 8;
  localparam int WD_CYCLES  = 50000;
  localparam int NVEC       = 10;

  // {expect_error, high word[23:0], low word}
  localparam logic [56:0] VECS [NVEC] = '{
    {1'b0, 24'h453010, 32'h02140725},
    {1'b1, 24'h453010, 32'h02141325},
    {1'b1, 24'h5A3010, 32'h02140725},
    {1'b1, 24'h453010, 32'h02310425},
    {1'b0, 24'h000000, 32'h04290224},
    {1'b1, 24'h000000, 32'h04290223},
    {1'b1, 24'h000024, 32'h02140725},
    {1'b1, 24'h000000, 32'h07010125},
    {1'b1, 24'h000000, 32'h02000125},
    {1'b0, 24'h595923, 32'h06311299}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_pps = 1'b0;
  logic        bus_we = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_cmd_bridge #(.CMD_CYCLES(CMD_CYC), .ADDR_W(2)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_pps  (tick_pps),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata)
  );

  task automatic chk(input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  // issue a command and time the busy window (R3)
  task automatic run_cmd(input logic [31:0] code);
    logic [31:0] c;
    wr(2'd0, code);
    rd(2'd0, c);
    chk("R3 ready low after accept", {31'd0, c[15]}, 32'd0);
    repeat (CMD_CYC - 1) @(negedge clk);
    rd(2'd0, c);
    chk("R3 ready low at last busy cycle", {31'd0, c[15]}, 32'd0);
    @(negedge clk);
    rd(2'd0, c);
    chk("R3 ready back after window", {31'd0, c[15]}, 32'd1);
  endtask

  task automatic set_time(input logic [31:0] lo, input logic [31:0] hi);
    wr(2'd0, 32'd0);
    wr(2'd1, lo);
    wr(2'd2, hi);
    run_cmd(32'd1);
  endtask

  task automatic get_time(output logic [31:0] lo, output logic [31:0] hi);
    wr(2'd0, 32'd0);
    run_cmd(32'd2);
    rd(2'd1, lo);
    rd(2'd2, hi);
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick_pps = 1'b1;
    @(negedge clk); tick_pps = 1'b0;
  endtask

  task automatic tick_case(input string req,
                           input logic [31:0] lo, input logic [31:0] hi,
                           input logic [31:0] elo, input logic [31:0] ehi);
    logic [31:0] a, b;
    set_time(lo, hi);
    pulse_tick();
    get_time(a, b);
    chk({req, " low word"}, a, elo);
    chk({req, " high word"}, b, ehi);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] lo, hi, c, exp_lo, exp_hi;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(2'd0, c);
    chk("R1 control after reset", c, 32'h0000_8000);
    get_time(lo, hi);
    chk("R1 reset date", lo, 32'h0601_0100);
    chk("R1 reset time", hi, 32'h0000_0000);

    // R2 data word mapping and readback
    wr(2'd0, 32'd0);
    wr(2'd1, 32'hA1B2_C3D4);
    wr(2'd2, 32'hFF12_3456);
    rd(2'd1, c);
    chk("R2 low word readback", c, 32'hA1B2_C3D4);
    rd(2'd2, c);
    chk("R2 high word upper byte zero", c, 32'h0012_3456);

    // vector table: R4 valid sets, R5 rejected sets, R6 read back
    exp_lo = 32'h0601_0100;
    exp_hi = 32'h0;
    for (int i = 0; i < NVEC; i++) begin
      set_time(VECS[i][31:0], {8'h00, VECS[i][55:32]});
      rd(2'd0, c);
      chk(VECS[i][56] ? "R5 error flag on bad record" : "R4 set accepted",
          c, VECS[i][56] ? 32'h0000_C001 : 32'h0000_8001);
      if (!VECS[i][56]) begin
        exp_lo = VECS[i][31:0];
        exp_hi = {8'h00, VECS[i][55:32]};
      end
      get_time(lo, hi);
      rd(2'd0, c);
      chk("R6 read completes without error", c, 32'h0000_8002);
      chk(VECS[i][56] ? "R5 time unchanged low" : "R4 loaded low", lo, exp_lo);
      chk(VECS[i][56] ? "R5 time unchanged high" : "R4 loaded high", hi, exp_hi);
    end

    // R7 clear wipes the error and last command
    set_time(32'h0214_1325, 32'h0);
    wr(2'd0, 32'd0);
    rd(2'd0, c);
    chk("R7 clear resets error", c, 32'h0000_8000);

    // R7 no re-arm without clear
    set_time(32'h0214_0725, 32'h0000_3010);
    wr(2'd0, 32'd2);
    rd(2'd0, c);
    chk("R7 command ignored until cleared", c, 32'h0000_8001);

    // R8 writes during busy ignored
    wr(2'd0, 32'd0);
    wr(2'd1, 32'h0301_0525);
    wr(2'd2, 32'h0000_0008);
    wr(2'd0, 32'd1);
    wr(2'd0, 32'd2);
    wr(2'd1, 32'h0402_0525);
    rd(2'd1, c);
    chk("R8 data write ignored while busy", c, 32'h0301_0525);
    repeat (CMD_CYC) @(negedge clk);
    rd(2'd0, c);
    chk("R8 control write ignored while busy", c, 32'h0000_8001);
    get_time(lo, hi);
    chk("R8 set from pre-busy data", lo, 32'h0301_0525);

    // R8 unknown code ignored
    wr(2'd0, 32'd0);
    wr(2'd0, 32'd3);
    rd(2'd0, c);
    chk("R8 code 3 ignored", c, 32'h0000_8000);
    wr(2'd0, 32'h0000_0101);
    rd(2'd0, c);
    chk("R8 code 0x101 ignored", c, 32'h0000_8000);

    // R9 / R10 tick carries
    tick_case("R9 minute carry", 32'h0214_0725, 32'h0059_3412,
              32'h0214_0725, 32'h0000_3512);
    tick_case("R9 century and weekday wrap", 32'h0631_1299, 32'h0059_5923,
              32'h0001_0100, 32'h0000_0000);
    tick_case("R10 leap February 28", 32'h0328_0224, 32'h0059_5923,
              32'h0429_0224, 32'h0000_0000);
    tick_case("R10 leap February 29", 32'h0429_0224, 32'h0059_5923,
              32'h0501_0324, 32'h0000_0000);
    tick_case("R10 plain February", 32'h0128_0223, 32'h0059_5923,
              32'h0201_0323, 32'h0000_0000);
    tick_case("R10 thirty-day month", 32'h0330_0425, 32'h0059_5923,
              32'h0401_0525, 32'h0000_0000);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule